// File: doc/BRIEF.md
# Preemptive Multi-Channel DMA Service Arbiter

This block decides which of the DMA channels the transfer engine serves next. Each channel raises a request line. The engine reports two events: the end of each word it moves, and the end of each burst. The arbiter answers with a one-hot grant that is registered and held for a whole burst. A new winner is chosen only when the engine is idle or when a burst ends.

Two schemes are available, chosen by a select input.

- **Rotating scheme.** Channels take turns in ascending index order and wrap from the last index back to index 0.
- **Priority scheme.** Each channel carries a two-bit level. The smallest level wins, and among equal levels the lowest index wins.

In the priority scheme, level 0 is urgent. A level-0 request from another channel takes over at the next word boundary. The interrupted channel is parked and resumes once the urgent burst ends. Only one channel can be parked at a time, and a level-0 channel is never interrupted.

Top module: `dma_chan_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the grant is all zero and the held and resume outputs are low.
- R2: At most one grant bit is set in any cycle.
- R3: With `schemeSel`=0, when a burst ends the grant passes to the first requesting channel above the current index, wrapping to index 0. The current channel is chosen again only if no other channel requests.
- R4: While a channel is granted, the grant does not change in any cycle without `burstDone`, unless a preemption by R7 occurs.
- R5: With `schemeSel`=1, a new grant goes to the requester with the smallest level. Channel i's level is `prioVec[2i+1:2i]`. Ties go to the lowest index.
- R7: With `schemeSel`=1, `wordDone` high and `burstDone` low, a preemption happens when the granted channel's level is not 0 and another channel requests at level 0. In the next cycle the grant moves to the lowest-index such channel and `preemptHeld` goes high.
- R8: No preemption happens in these cases: with `schemeSel`=0; while `preemptHeld` is high; or when the granted channel has level 0.
- R9: A `burstDone` while `preemptHeld` is high returns the grant to the parked channel in the next cycle. In that cycle `preemptHeld` drops and `resumePulse` is high for exactly one cycle.
- R10: With no grant, a request is granted in the next cycle. A `burstDone` with no requests leaves the grant empty in the next cycle, and the grant stays empty while nothing requests.
- R11: When `burstDone` and `wordDone` are high together, normal burst-boundary arbitration takes place and no preemption occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_CH | Per-channel service request, bit i for channel i |
| prioVec | input | NUM_CH*PRIO_W | Per-channel level, bits [2i+1:2i] for channel i |
| schemeSel | input | 1 | 0 selects rotating, 1 selects level-based |
| wordDone | input | 1 | Engine finished a word this cycle |
| burstDone | input | 1 | Engine finished a burst this cycle |
| grantOh | output | NUM_CH | One-hot grant of the served channel |
| preemptHeld | output | 1 | A channel is parked behind an urgent burst |
| resumePulse | output | 1 | One-cycle pulse when the parked channel is restored |

## Verification
The bench builds the block with its defaults: ten channels and two-bit levels. This makes the wrap from index 9 back to index 0 observable, and it allows all four levels to be mixed. With these values a level-0 request, a ten-way tie and the lowest-index tie-break can all appear in one request pattern. The stimulus includes several cases: a nested urgent request while a channel is parked; an urgent request that meets an urgent granted channel; and simultaneous word and burst ends. The bench also asserts reset while a channel is parked.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HELD} arbState_t;

  typedef struct packed {
    logic load;
    logic preempt;
    logic restore;
    logic drop;
  } arbStrobe_t;
endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       prioMode,
  input  logic       anyReq,
  input  logic       p0Avail,
  input  logic       wordDone,
  input  logic       burstDone,
  output arbStrobe_t strobe
);
  arbState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: if (anyReq) begin
        strobe.load = 1'b1;
        stateNext   = ST_RUN;
      end
      ST_RUN: begin
        if (burstDone) begin
          if (anyReq) strobe.load = 1'b1;
          else begin
            strobe.drop = 1'b1;
            stateNext   = ST_IDLE;
          end
        end else if (wordDone && prioMode && p0Avail) begin
          strobe.preempt = 1'b1;
          stateNext      = ST_HELD;
        end
      end
      ST_HELD: if (burstDone) begin
        strobe.restore = 1'b1;
        stateNext      = ST_RUN;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/dma_arb_dp.sv
module dma_arb_dp
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int PRIO_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        reqVec,
  input  logic [NUM_CH*PRIO_W-1:0] prioVec,
  input  logic                     prioMode,
  input  arbStrobe_t               strobe,
  output logic                     anyReq,
  output logic                     p0Avail,
  output logic [NUM_CH-1:0]        grantOh,
  output logic                     preemptHeld,
  output logic                     resumePulse
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  logic [PRIO_W-1:0] prioLvl [NUM_CH];
  logic [CH_W-1:0]   curCh, savedCh, rrPick, lvlPick, p0Pick, pick;
  logic              curValid, p0Found;
  logic [PRIO_W:0]   bestLvl;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_unpack
    assign prioLvl[i] = prioVec[i*PRIO_W +: PRIO_W];
    assign grantOh[i] = curValid && (curCh == CH_W'(i));
  end

  assign anyReq = |reqVec;

  // Rotating pick: first requester after curCh, curCh itself last.
  always_comb begin
    logic hit;
    hit    = 1'b0;
    rrPick = curCh;
    for (int k = 1; k <= NUM_CH; k++) begin
      int idx;
      idx = (int'(curCh) + k) % NUM_CH;
      if (!hit && reqVec[idx]) begin
        hit    = 1'b1;
        rrPick = CH_W'(idx);
      end
    end
  end

  // Level pick: smallest level, strict compare keeps lowest index on ties.
  always_comb begin
    bestLvl = {1'b1, {PRIO_W{1'b0}}};
    lvlPick = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reqVec[i] && ({1'b0, prioLvl[i]} < bestLvl)) begin
        bestLvl = {1'b0, prioLvl[i]};
        lvlPick = CH_W'(i);
      end
    end
  end

  // Urgent pick: lowest-index level-0 requester other than the granted one.
  always_comb begin
    p0Found = 1'b0;
    p0Pick  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (reqVec[i] && (prioLvl[i] == '0) && (CH_W'(i) != curCh)) begin
        p0Found = 1'b1;
        p0Pick  = CH_W'(i);
      end
    end
  end

  assign pick    = prioMode ? lvlPick : rrPick;
  assign p0Avail = p0Found && curValid && (prioLvl[curCh] != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curCh       <= LAST_CH;
      curValid    <= 1'b0;
      savedCh     <= '0;
      preemptHeld <= 1'b0;
      resumePulse <= 1'b0;
    end else begin
      resumePulse <= strobe.restore;
      if (strobe.load) begin
        curCh    <= pick;
        curValid <= 1'b1;
      end else if (strobe.preempt) begin
        savedCh     <= curCh;
        preemptHeld <= 1'b1;
        curCh       <= p0Pick;
      end else if (strobe.restore) begin
        curCh       <= savedCh;
        preemptHeld <= 1'b0;
      end else if (strobe.drop) begin
        curValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 10,
  parameter int PRIO_W = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        reqVec,
  input  logic [NUM_CH*PRIO_W-1:0] prioVec,
  input  logic                     schemeSel,
  input  logic                     wordDone,
  input  logic                     burstDone,
  output logic [NUM_CH-1:0]        grantOh,
  output logic                     preemptHeld,
  output logic                     resumePulse
);
  arbStrobe_t strobe;
  logic       anyReq, p0Avail;

  dma_arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .prioMode(schemeSel), .anyReq(anyReq),
    .p0Avail(p0Avail), .wordDone(wordDone), .burstDone(burstDone),
    .strobe(strobe)
  );

  dma_arb_dp #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_dp (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .prioMode(schemeSel), .strobe(strobe), .anyReq(anyReq),
    .p0Avail(p0Avail), .grantOh(grantOh), .preemptHeld(preemptHeld),
    .resumePulse(resumePulse)
  );
endmodule

// File: rtl/dma_chan_arbiter_chk.sv
module dma_chan_arbiter_chk #(
  parameter int NUM_CH = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] reqVec,
  input logic              schemeSel,
  input logic              wordDone,
  input logic              burstDone,
  input logic [NUM_CH-1:0] grantOh,
  input logic              preemptHeld,
  input logic              resumePulse
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOh)); // R2
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((|grantOh) && !burstDone && !wordDone) |=> $stable(grantOh)); // R4
  AST_PREEMPT_AT_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(preemptHeld) |-> ($past(wordDone) && $past(schemeSel) && !$past(burstDone))); // R7
  AST_NO_PREEMPT_ROTATE: assert property (@(posedge clk) disable iff (!rstN)
    (!schemeSel && !preemptHeld) |=> !preemptHeld); // R8
  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> (!preemptHeld && $past(preemptHeld))); // R9
  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |=> !resumePulse); // R9
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (!(|reqVec) && !(|grantOh)) |=> !(|grantOh)); // R10
endmodule

bind dma_chan_arbiter dma_chan_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .reqVec(reqVec), .schemeSel(schemeSel),
  .wordDone(wordDone), .burstDone(burstDone), .grantOh(grantOh),
  .preemptHeld(preemptHeld), .resumePulse(resumePulse)
);

// File: tb/dma_chan_arbiter_bench.sv
module dma_chan_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 10;
  localparam int PW  = 2;

  typedef struct packed {
    logic [3:0]      tag;
    logic [NCH-1:0]  req;
    logic [NCH*PW-1:0] prio;
    logic            sch, wd, bd;
    logic [NCH-1:0]  g;
    logic            h, r;
  } row_t;

  localparam int NROWS = 23;
  localparam row_t VEC [NROWS] = '{
    '{4'd10, 10'h000, 20'h55555, 1'b0, 1'b0, 1'b0, 10'h000, 1'b0, 1'b0},
    '{4'd10, 10'h024, 20'h55555, 1'b0, 1'b0, 1'b0, 10'h004, 1'b0, 1'b0},
    '{4'd4,  10'h024, 20'h55555, 1'b0, 1'b1, 1'b0, 10'h004, 1'b0, 1'b0},
    '{4'd3,  10'h024, 20'h55555, 1'b0, 1'b0, 1'b1, 10'h020, 1'b0, 1'b0},
    '{4'd3,  10'h024, 20'h55555, 1'b0, 1'b0, 1'b1, 10'h004, 1'b0, 1'b0},
    '{4'd3,  10'h204, 20'h55555, 1'b0, 1'b0, 1'b1, 10'h200, 1'b0, 1'b0},
    '{4'd3,  10'h201, 20'h55555, 1'b0, 1'b0, 1'b1, 10'h001, 1'b0, 1'b0},
    '{4'd10, 10'h000, 20'h55555, 1'b0, 1'b0, 1'b1, 10'h000, 1'b0, 1'b0},
    '{4'd5,  10'h112, 20'h6565D, 1'b1, 1'b0, 1'b0, 10'h010, 1'b0, 1'b0},
    '{4'd5,  10'h112, 20'h6565D, 1'b1, 1'b0, 1'b1, 10'h010, 1'b0, 1'b0},
    '{4'd5,  10'h112, 20'h5565D, 1'b1, 1'b0, 1'b1, 10'h100, 1'b0, 1'b0},
    '{4'd4,  10'h11A, 20'h5561D, 1'b1, 1'b0, 1'b0, 10'h100, 1'b0, 1'b0},
    '{4'd7,  10'h11A, 20'h5561D, 1'b1, 1'b1, 1'b0, 10'h008, 1'b1, 1'b0},
    '{4'd8,  10'h11B, 20'h5561C, 1'b1, 1'b1, 1'b0, 10'h008, 1'b1, 1'b0},
    '{4'd9,  10'h11B, 20'h5561C, 1'b1, 1'b0, 1'b1, 10'h100, 1'b0, 1'b1},
    '{4'd9,  10'h11B, 20'h5561C, 1'b1, 1'b0, 1'b0, 10'h100, 1'b0, 1'b0},
    '{4'd7,  10'h11B, 20'h5561C, 1'b1, 1'b1, 1'b0, 10'h001, 1'b1, 1'b0},
    '{4'd9,  10'h11B, 20'h5561C, 1'b1, 1'b0, 1'b1, 10'h100, 1'b0, 1'b1},
    '{4'd11, 10'h11B, 20'h5561C, 1'b1, 1'b1, 1'b1, 10'h001, 1'b0, 1'b0},
    '{4'd8,  10'h11B, 20'h5561C, 1'b1, 1'b1, 1'b0, 10'h001, 1'b0, 1'b0},
    '{4'd8,  10'h11B, 20'h5561C, 1'b0, 1'b1, 1'b0, 10'h001, 1'b0, 1'b0},
    '{4'd3,  10'h11B, 20'h5561C, 1'b0, 1'b0, 1'b1, 10'h002, 1'b0, 1'b0},
    '{4'd10, 10'h000, 20'h5561C, 1'b0, 1'b0, 1'b1, 10'h000, 1'b0, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic [NCH-1:0]    reqVec;
  logic [NCH*PW-1:0] prioVec;
  logic              schemeSel, wordDone, burstDone;
  logic [NCH-1:0]    grantOh;
  logic              preemptHeld, resumePulse;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_arbiter #(.NUM_CH(NCH), .PRIO_W(PW)) u_dma_chan_arbiter (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .prioVec(prioVec),
    .schemeSel(schemeSel), .wordDone(wordDone), .burstDone(burstDone),
    .grantOh(grantOh), .preemptHeld(preemptHeld), .resumePulse(resumePulse)
  );

  function automatic string tagName(logic [3:0] t);
    case (t)
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic checkOut(string tag, logic [NCH-1:0] g, logic h, logic r);
    checks++;
    if (grantOh !== g || preemptHeld !== h || resumePulse !== r) begin
      failures++;
      $display("FAIL %s: grant=%h held=%b resume=%b expected grant=%h held=%b resume=%b",
               tag, grantOh, preemptHeld, resumePulse, g, h, r);
    end
    checks++;
    if ($countones(grantOh) > 1) begin
      failures++;
      $display("FAIL R2: grant=%h expected at most one bit", grantOh);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; reqVec = '0; prioVec = 20'h55555;
    schemeSel = 1'b0; wordDone = 1'b0; burstDone = 1'b0;
    repeat (3) @(negedge clk);
    checkOut("R1", '0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1", '0, 1'b0, 1'b0);

    for (int i = 0; i < NROWS; i++) begin
      reqVec    = VEC[i].req;
      prioVec   = VEC[i].prio;
      schemeSel = VEC[i].sch;
      wordDone  = VEC[i].wd;
      burstDone = VEC[i].bd;
      @(negedge clk);
      checkOut(tagName(VEC[i].tag), VEC[i].g, VEC[i].h, VEC[i].r);
    end

    // R10: idle grant, then R7 preempt, then R1 reset while parked
    reqVec = 10'h004; prioVec = 20'h55555; schemeSel = 1'b1;
    wordDone = 1'b0; burstDone = 1'b0;
    @(negedge clk);
    checkOut("R10", 10'h004, 1'b0, 1'b0);
    reqVec = 10'h005; prioVec = 20'h55554; wordDone = 1'b1;
    @(negedge clk);
    checkOut("R7", 10'h001, 1'b1, 1'b0);
    wordDone = 1'b0; rstN = 1'b0;
    @(negedge clk);
    checkOut("R1", '0, 1'b0, 1'b0);
    rstN = 1'b1; reqVec = '0;
    @(negedge clk);
    checkOut("R1", '0, 1'b0, 1'b0);

    done = 1'b1;
    finishRun();
  end
endmodule